// File: doc/BRIEF.md
# Bit-Extraction Hash Unit

This block turns a stream of 32-bit integer keys into short hash values for indexing hash-table buckets. A programmable selection mask marks which key bits matter. For each key, the unit collects the key bits at the marked positions and packs them into a dense result with no gaps. A mask that marks n bits therefore addresses 2^n buckets.

Software loads the mask and a batch length in one configuration write. The unit then takes exactly that many keys on a valid/ready input stream. It returns one hash per key, in input order, on a valid/ready output stream. At full rate it accepts a new key every cycle. The mask is decoded once, when it is loaded, so the gather on each key is a single layer of multiplexers. A new mask can be loaded between batches, so the hash can be fitted to the data set.

Top module: `bext_hash_unit`

## Requirements
- R1: Hash bit k equals the key bit at the k-th lowest set position of the loaded mask, counting k from 0.
- R2: Hash bits at index n and above are zero, where n is the number of set mask bits, capped at 16.
- R3: With mask 0x00000514 (bits 2, 4, 8 and 10 set), keys 0x514, 0x4, 0x400, 0x110 and 0xFFFFFAEB give the hashes 0xF, 0x1, 0x8, 0x6 and 0x0.
- R4: A key accepted at a clock edge appears on `out_hash` with `out_valid` high after that edge. While `out_ready` stays high, `in_ready` never drops inside a batch.
- R5: After a configuration write with count N > 0, exactly N keys are accepted and exactly N hashes are delivered, in input order. `in_ready` is low outside a batch.
- R6: If the mask has more than 16 set bits, only its 16 lowest set positions are used. `mask_err` then goes high and stays high until reset.
- R7: While a batch is in flight, `cfg_ready` is low. A configuration write in that time is ignored: the mask and the count stay unchanged.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_hash` keeps its value on the next cycle.
- R9: `batch_done` is high for exactly one cycle: the cycle after the last hash of a batch is accepted.
- R10: After reset, `out_valid`, `in_ready`, `batch_done` and `mask_err` are low and `cfg_ready` is high.
- R11: A configuration write with count 0 loads the mask but starts no batch. `cfg_ready` stays high and `in_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mask | input | 32 | Selection mask to load |
| cfg_count | input | 16 | Number of keys in the batch |
| cfg_ready | output | 1 | High when a configuration write will be taken |
| in_valid | input | 1 | Key present |
| in_ready | output | 1 | Unit takes a key at this edge |
| in_key | input | 32 | Key |
| out_valid | output | 1 | Hash present |
| out_ready | input | 1 | Consumer takes the hash |
| out_hash | output | 16 | Packed hash value |
| batch_done | output | 1 | One-cycle pulse after the last hash of a batch |
| mask_err | output | 1 | Sticky flag: a loaded mask had more than 16 set bits |

## Verification
Each hash is registered once. It is due at the first falling edge after the rising edge that accepted its key. `batch_done` follows one edge after the last output handshake. A configuration write shows its effect on `cfg_ready` and `mask_err` at the falling edge right after the write edge. The bench drives inputs just after rising edges and samples everything at falling edges. At each falling edge, the driver pushes the expected hash for a key it sees accepted. At the same falling edges, a monitor pops expected values against output handshakes. The monitor also checks for the done pulse exactly one falling edge after the final pop.

// File: rtl/bext_pkg.sv
// Package: shared sizes and derived widths for the bit-extraction hash unit.
// Assumes a key no wider than 64 bits so index fields stay small.
package bext_pkg;
    localparam int KEY_W_D  = 32;
    localparam int HASH_W_D = 16;
    localparam int CNT_W_D  = 16;
endpackage

// File: rtl/bext_mask_decode.sv
// Module: converts a selection mask into per-output-bit source indices.
// Output slot k receives the position of the k-th lowest set mask bit.
// Slots beyond the population stay invalid. Extra set bits raise 'over'.
// Purely combinational; the caller registers the result.
module bext_mask_decode #(
    parameter int KEY_W  = bext_pkg::KEY_W_D,
    parameter int HASH_W = bext_pkg::HASH_W_D,
    localparam int IDX_W = $clog2(KEY_W),
    localparam int SLT_W = $clog2(HASH_W)
) (
    input  logic [KEY_W-1:0]              mask,
    output logic [HASH_W-1:0][IDX_W-1:0]  sel_idx,
    output logic [HASH_W-1:0]             sel_vld,
    output logic                          over
);
    localparam logic [IDX_W:0] CAP = (IDX_W+1)'(HASH_W);

    // Scan the mask from bit 0 upward and assign slots in order.
    always_comb begin
        logic [IDX_W:0] n;
        n       = '0;
        sel_idx = '0;
        sel_vld = '0;
        for (int i = 0; i < KEY_W; i++) begin
            if (mask[i]) begin
                if (n < CAP) begin
                    sel_idx[n[SLT_W-1:0]] = IDX_W'(i);
                    sel_vld[n[SLT_W-1:0]] = 1'b1;
                end
                n = n + 1'b1;
            end
        end
        over = (n > CAP);
    end
endmodule

// File: rtl/bext_gather.sv
// Module: picks one key bit per hash slot using pre-decoded indices.
// Assumes sel_idx/sel_vld come from bext_mask_decode; invalid slots give 0.
module bext_gather #(
    parameter int KEY_W  = bext_pkg::KEY_W_D,
    parameter int HASH_W = bext_pkg::HASH_W_D,
    localparam int IDX_W = $clog2(KEY_W)
) (
    input  logic [KEY_W-1:0]              key,
    input  logic [HASH_W-1:0][IDX_W-1:0]  sel_idx,
    input  logic [HASH_W-1:0]             sel_vld,
    output logic [HASH_W-1:0]             hash
);
    for (genvar k = 0; k < HASH_W; k++) begin : g_slot
        // One KEY_W:1 multiplexer per output bit, gated by its slot valid.
        assign hash[k] = sel_vld[k] & key[sel_idx[k]];
    end
endmodule

// File: rtl/bext_batch_ctrl.sv
// Module: tracks keys still to accept and hashes still to deliver in a batch.
// Assumes 'start' only arrives while idle (busy low) and that the fire
// strobes never exceed the loaded count.
module bext_batch_ctrl #(
    parameter int CNT_W = bext_pkg::CNT_W_D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] start_count,
    input  logic             in_fire,
    input  logic             out_fire,
    output logic             keys_open,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] keys_left;
    logic [CNT_W-1:0] outs_left;

    // Count down accepted keys from the loaded batch length.
    always_ff @(posedge clk) begin
        if (!rst_n)       keys_left <= '0;
        else if (start)   keys_left <= start_count;
        else if (in_fire) keys_left <= keys_left - 1'b1;
    end

    // Count down delivered hashes; the batch ends when this reaches zero.
    always_ff @(posedge clk) begin
        if (!rst_n)        outs_left <= '0;
        else if (start)    outs_left <= start_count;
        else if (out_fire) outs_left <= outs_left - 1'b1;
    end

    // Pulse done one cycle after the final hash handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= out_fire && (outs_left == CNT_W'(1));
    end

    assign keys_open = (keys_left != '0);
    assign busy      = (outs_left != '0);
endmodule

// File: rtl/bext_hash_unit.sv
// Module: top of the bit-extraction hash unit.
// A configuration write (only while idle) loads the mask and a batch length.
// The mask is decoded into slot indices at load time. Each accepted key is
// gathered and registered, giving one hash per cycle at one cycle latency.
// Assumes a single producer and a single consumer on valid/ready streams.
module bext_hash_unit #(
    parameter int KEY_W  = bext_pkg::KEY_W_D,
    parameter int HASH_W = bext_pkg::HASH_W_D,
    parameter int CNT_W  = bext_pkg::CNT_W_D,
    localparam int IDX_W = $clog2(KEY_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [KEY_W-1:0]  cfg_mask,
    input  logic [CNT_W-1:0]  cfg_count,
    output logic              cfg_ready,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [KEY_W-1:0]  in_key,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [HASH_W-1:0] out_hash,
    output logic              batch_done,
    output logic              mask_err
);
    logic [HASH_W-1:0][IDX_W-1:0] dec_idx, sel_idx;
    logic [HASH_W-1:0]            dec_vld, sel_vld;
    logic                         dec_over;
    logic [HASH_W-1:0]            hash_c;
    logic                         cfg_take, in_fire, out_fire, keys_open, busy;

    bext_mask_decode #(.KEY_W(KEY_W), .HASH_W(HASH_W)) u_decode (
        .mask    (cfg_mask),
        .sel_idx (dec_idx),
        .sel_vld (dec_vld),
        .over    (dec_over)
    );

    bext_gather #(.KEY_W(KEY_W), .HASH_W(HASH_W)) u_gather (
        .key     (in_key),
        .sel_idx (sel_idx),
        .sel_vld (sel_vld),
        .hash    (hash_c)
    );

    bext_batch_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (cfg_take),
        .start_count (cfg_count),
        .in_fire     (in_fire),
        .out_fire    (out_fire),
        .keys_open   (keys_open),
        .busy        (busy),
        .done        (batch_done)
    );

    assign cfg_ready = !busy;
    assign cfg_take  = cfg_we && cfg_ready;
    assign in_ready  = keys_open && (!out_valid || out_ready);
    assign in_fire   = in_valid && in_ready;
    assign out_fire  = out_valid && out_ready;

    // Hold the decoded mask; it changes only on an accepted configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_idx <= '0;
            sel_vld <= '0;
        end else if (cfg_take) begin
            sel_idx <= dec_idx;
            sel_vld <= dec_vld;
        end
    end

    // Sticky flag for masks wider than the hash.
    always_ff @(posedge clk) begin
        if (!rst_n)                    mask_err <= 1'b0;
        else if (cfg_take && dec_over) mask_err <= 1'b1;
    end

    // Output register: load on accept, clear when drained, hold while stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hash  <= '0;
        end else if (in_fire) begin
            out_valid <= 1'b1;
            out_hash  <= hash_c;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/bext_hash_unit_chk.sv
// Module: assertion checker bound to bext_hash_unit.
// Observes ports and the registered slot decode; drives nothing.
module bext_hash_unit_chk #(
    parameter int KEY_W  = bext_pkg::KEY_W_D,
    parameter int HASH_W = bext_pkg::HASH_W_D,
    localparam int IDX_W = $clog2(KEY_W)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_ready,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [HASH_W-1:0]       out_hash,
    input logic                    batch_done,
    input logic                    mask_err,
    input logic [HASH_W-1:0]       sel_vld,
    input logic [HASH_W*IDX_W-1:0] sel_idx
);
    int nsel;
    // Number of live hash slots from the registered decode.
    always_comb nsel = $countones(sel_vld);

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_hash >> nsel) == '0));

    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    p_ready_in_batch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !cfg_ready);

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mask_err |=> mask_err);

    p_cfg_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ready |=> ($stable(sel_vld) && $stable(sel_idx)));

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_hash)));

    p_done_after_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        batch_done |-> $past(out_valid && out_ready));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        batch_done |=> !batch_done);
endmodule

bind bext_hash_unit bext_hash_unit_chk #(.KEY_W(KEY_W), .HASH_W(HASH_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_ready  (cfg_ready),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_hash   (out_hash),
    .batch_done (batch_done),
    .mask_err   (mask_err),
    .sel_vld    (sel_vld),
    .sel_idx    (sel_idx)
);

// File: tb/test_bext_hash_unit.sv
// Bench: scoreboard-based test of bext_hash_unit.
// The driver pushes expected hashes; the monitor pops them at output handshakes.
module test_bext_hash_unit;
    localparam int CLK_PERIOD = 10;
    localparam int KW = 32;
    localparam int HW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [KW-1:0] cfg_mask = '0;
    logic [CW-1:0] cfg_count = '0;
    logic          cfg_ready;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [KW-1:0] in_key = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [HW-1:0] out_hash;
    logic          batch_done;
    logic          mask_err;

    bext_hash_unit i_bext_hash_unit (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mask(cfg_mask),
        .cfg_count(cfg_count), .cfg_ready(cfg_ready), .in_valid(in_valid),
        .in_ready(in_ready), .in_key(in_key), .out_valid(out_valid),
        .out_ready(out_ready), .out_hash(out_hash), .batch_done(batch_done),
        .mask_err(mask_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int            checks = 0;
    int            errors = 0;
    logic [HW-1:0] exp_q[$];
    logic [KW-1:0] keys_buf[64];
    logic [HW-1:0] exp_buf[64];
    string         cur_req = "R1 R2";
    logic          stall_mode = 1'b0;
    logic          all_sent = 1'b0;
    logic          done_exp = 1'b0;
    logic          hold_pend = 1'b0;
    logic [HW-1:0] held;
    logic [15:0]   lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Bench model: pack key bits at the lowest 16 set mask positions.
    function automatic logic [HW-1:0] ref_hash(input logic [KW-1:0] m, input logic [KW-1:0] k);
        logic [HW-1:0] r = '0;
        int n = 0;
        for (int i = 0; i < KW; i++) begin
            if (m[i]) begin
                if (n < HW) r[n] = k[i];
                n++;
            end
        end
        return r;
    endfunction

    // Consumer: ready always high, or pseudo-random when stalling.
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = stall_mode ? lfsr[0] : 1'b1;
    end

    // Monitor: scoreboard pops, stall hold and done pulse.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(batch_done == done_exp, "R9", "batch_done", 32'(batch_done), 32'(done_exp));
            done_exp = 1'b0;
            if (hold_pend) begin
                chk(out_valid && out_hash == held, "R8", "held hash", 32'(out_hash), 32'(held));
                hold_pend = 1'b0;
            end
            if (out_valid && !out_ready) begin
                hold_pend = 1'b1;
                held = out_hash;
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", "extra hash", 32'(out_hash), 32'hFFFFFFFF);
                end else begin
                    logic [HW-1:0] e;
                    e = exp_q.pop_front();
                    chk(out_hash == e, cur_req, "hash", 32'(out_hash), 32'(e));
                    if (exp_q.size() == 0 && all_sent) done_exp = 1'b1;
                end
            end
        end
    end

    task automatic cfg_write(input logic [KW-1:0] m, input logic [CW-1:0] c, output logic rdy);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_mask = m; cfg_count = c;
        @(negedge clk);
        rdy = cfg_ready;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic fill(input logic [KW-1:0] m, input int n, input logic [KW-1:0] seed);
        for (int i = 0; i < n; i++) begin
            keys_buf[i] = (KW'(i) * 32'h9E3779B9) ^ seed;
            exp_buf[i]  = ref_hash(m, keys_buf[i]);
        end
    endtask

    task automatic send_batch(input int n);
        int idx = 0;
        int stalls = 0;
        bit prev = 1'b0;
        all_sent = 1'b0;
        in_valid = 1'b1;
        in_key = keys_buf[0];
        while (idx < n) begin
            @(negedge clk);
            if (prev && !stall_mode)
                chk(out_valid == 1'b1, "R4", "latency", 32'(out_valid), 32'd1);
            prev = 1'b0;
            if (in_ready) begin
                exp_q.push_back(exp_buf[idx]);
                idx++;
                prev = 1'b1;
                if (idx == n) all_sent = 1'b1;
            end else if (!stall_mode) begin
                stalls++;
            end
            @(posedge clk); #1;
            if (idx < n) in_key = keys_buf[idx];
            else         in_valid = 1'b0;
        end
        if (!stall_mode) chk(stalls == 0, "R4", "input stalls", 32'(stalls), 32'd0);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(!in_ready && cfg_ready, "R5", "idle after batch",
            32'({in_ready, cfg_ready}), 32'b01);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hang counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic rdy;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !in_ready && !batch_done && !mask_err && cfg_ready, "R10",
            "reset outputs", 32'({out_valid, in_ready, batch_done, mask_err, cfg_ready}), 32'b00001);

        // R3: fixed example mask with literal expectations.
        cur_req = "R3";
        cfg_write(32'h514, 16'd5, rdy);
        chk(rdy, "R3", "cfg ready", 32'(rdy), 32'd1);
        keys_buf[0] = 32'h514;      exp_buf[0] = 16'hF;
        keys_buf[1] = 32'h4;        exp_buf[1] = 16'h1;
        keys_buf[2] = 32'h400;      exp_buf[2] = 16'h8;
        keys_buf[3] = 32'h110;      exp_buf[3] = 16'h6;
        keys_buf[4] = 32'hFFFFFAEB; exp_buf[4] = 16'h0;
        send_batch(5);

        // R1 R2: several masks, full rate.
        cur_req = "R1 R2";
        cfg_write(32'h80000001, 16'd12, rdy); fill(32'h80000001, 12, 32'h1234); send_batch(12);
        cfg_write(32'h0F0F0000, 16'd12, rdy); fill(32'h0F0F0000, 12, 32'h5A5A); send_batch(12);
        cfg_write(32'h12345678, 16'd12, rdy); fill(32'h12345678, 12, 32'hBEEF); send_batch(12);
        cfg_write(32'h0, 16'd4, rdy);         fill(32'h0, 4, 32'hFFFF);         send_batch(4);

        // R8: consumer back-pressure with a full 16-bit mask.
        cur_req = "R8 R1";
        stall_mode = 1'b1;
        cfg_write(32'hFFFF0000, 16'd20, rdy); fill(32'hFFFF0000, 20, 32'h7777); send_batch(20);
        stall_mode = 1'b0;

        // R6: overwide masks keep the lowest 16 positions and set a sticky flag.
        cur_req = "R6";
        chk(!mask_err, "R6", "flag before", 32'(mask_err), 32'd0);
        cfg_write(32'hFFFFFFFF, 16'd4, rdy);
        chk(mask_err, "R6", "flag set", 32'(mask_err), 32'd1);
        for (int i = 0; i < 4; i++) begin
            keys_buf[i] = 32'hC3A50000 + KW'(i * 32'h1111);
            exp_buf[i] = keys_buf[i][15:0];
        end
        send_batch(4);
        cfg_write(32'h0001FFFF, 16'd3, rdy); fill(32'h0000FFFF, 3, 32'h3C3C); send_batch(3);
        cfg_write(32'h000000F0, 16'd3, rdy); fill(32'h000000F0, 3, 32'h0F0F); send_batch(3);
        chk(mask_err, "R6", "flag sticky", 32'(mask_err), 32'd1);

        // R7: a write during a batch is ignored.
        cur_req = "R7";
        cfg_write(32'h3, 16'd3, rdy);
        chk(rdy, "R7", "first write", 32'(rdy), 32'd1);
        cfg_write(32'hC, 16'd5, rdy);
        chk(!rdy, "R7", "busy write", 32'(rdy), 32'd0);
        fill(32'h3, 3, 32'h0001);
        send_batch(3);

        // R11: zero count loads but starts nothing.
        cfg_write(32'h1, 16'd0, rdy);
        @(negedge clk);
        chk(cfg_ready && !in_ready && !out_valid, "R11", "zero count",
            32'({cfg_ready, in_ready, out_valid}), 32'b100);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule